// File: doc/BRIEF.md
# Kernel Trap and Preemption Controller

This block owns the processor's privilege state and the small set of special registers that the kernel consults when it gains control. It watches trap sources while user code runs: an address fault from the memory management unit, a protected instruction flagged by decode, a system call, an external IO interrupt, and its own preemption countdown. When any of them fires, it produces a one-cycle redirect strobe. The strobe carries a fixed kernel entry address. On the same clock edge the block drops to kernel mode, saves the interrupted program counter and the r7 register, and records a cause code. For an address fault it also saves the failing virtual address.

The kernel drives the block through a small command port. One command loads the preemption countdown and another returns the processor to user mode. The kernel reads the saved state back through a register-select read port. The countdown runs only in user mode. A loaded value of zero leaves it idle, so preemption stays off until the timer is loaded again. While the processor is in kernel mode, every trap request is masked.

Top module: `kernel_trap_unit`

## Requirements
- R1: After a synchronous active-low reset, the processor is in kernel mode, the redirect strobe is low, and the countdown, cause, saved PC, saved r7 and fault address all read zero.
- R2: In kernel mode, command code 1 loads the countdown from the write data, and command code 2 switches to user mode from the next cycle.
- R3: The countdown drops by one on each clock edge spent in user mode. It holds its value in kernel mode and while it is zero.
- R4: In user mode, a countdown value of one raises a timeout trap in that cycle, and the countdown reaches zero on the same edge. A countdown loaded with zero never raises a timeout.
- R5: A taken trap raises the redirect strobe in the cycle the request is seen, with the redirect address equal to the fixed entry address. On the next edge, kernel mode is set, the saved PC takes the current PC, and the saved r7 takes the current r7.
- R6: An address-fault trap stores the fault address. Every other trap, and every cycle without a trap, leaves the stored fault address unchanged.
- R7: A protected-instruction flag in user mode traps with cause 3. The same flag in kernel mode has no effect.
- R8: Cause codes sit in bits 3:0 of the cause register: 1 timeout, 2 address fault, 3 protected instruction, 4 system call, 5 IO interrupt. Among requests that arrive together, the lowest code wins.
- R9: In kernel mode, no trap request raises the strobe or changes the mode, the saved PC or the cause.
- R10: Commands issued in user mode are ignored: the countdown keeps counting and the mode stays user.
- R11: A trap other than a timeout freezes the countdown on its edge, so the countdown keeps its pre-trap value.
- R12: Read select codes are 0 countdown, 1 cause, 2 saved PC, 3 fault address, 4 saved r7, and 5 fixed entry address. Codes 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_pc | input | 16 | PC of the instruction in flight |
| cur_r7 | input | 16 | Current value of r7 |
| mmu_fault | input | 1 | Address fault reported by the MMU |
| mmu_fault_addr | input | 16 | Virtual address that faulted |
| priv_issue | input | 1 | Decode issued a protected instruction |
| sys_req | input | 1 | System call request |
| io_irq | input | 1 | External IO interrupt |
| cmd_op | input | 2 | Kernel command: 0 none, 1 load countdown, 2 enter user |
| cmd_wdata | input | 16 | Countdown load value |
| rd_sel | input | 3 | Special register select |
| user_mode | output | 1 | 1 while the processor is in user mode |
| redirect_valid | output | 1 | One-cycle redirect strobe on trap entry |
| redirect_pc | output | 16 | Kernel entry address |
| rd_data | output | 16 | Selected special register |

## Verification
The bench walks the countdown through its final steps. A design that fires one cycle late, or that leaves the countdown at one, would re-enter the kernel as soon as user mode resumes. It also shows that a zero load stays silent for many user cycles, where an unguarded decrement would wrap and later fire a timeout nobody asked for. Simultaneous requests test the priority order. A wrong order shows up as the wrong cause code, or as a fault address taken from a trap that was not the winner. The bench also drives every trap source in kernel mode and issues commands from user mode. A design that fails to mask these would overwrite the saved PC and lose the interrupted context, or would let user code reload the countdown.

// File: rtl/ktu_pkg.sv
// Package: shared codes for the kernel trap and preemption controller.
// Assumes cause codes fit in four bits and that the trap source order equals
// the cause order (index i carries code i+1).
package ktu_pkg;

    localparam int unsigned NUM_SRC  = 5;
    localparam int unsigned CAUSE_W  = 4;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 4'd0,
        CAUSE_TIMEOUT = 4'd1,
        CAUSE_SEGV    = 4'd2,
        CAUSE_PRIV    = 4'd3,
        CAUSE_SYSCALL = 4'd4,
        CAUSE_IO      = 4'd5
    } cause_e;

    typedef enum logic [1:0] {
        KOP_NONE       = 2'd0,
        KOP_LOAD_TIMER = 2'd1,
        KOP_ENTER_USER = 2'd2,
        KOP_RSVD       = 2'd3
    } kop_e;

    typedef enum logic [2:0] {
        RSEL_TIMER   = 3'd0,
        RSEL_CAUSE   = 3'd1,
        RSEL_ERET    = 3'd2,
        RSEL_EADDR   = 3'd3,
        RSEL_CONTEXT = 3'd4,
        RSEL_ISR     = 3'd5
    } rsel_e;

endpackage

// File: rtl/ktu_prio.sv
// Module: fixed-priority selector over trap sources.
// Does: grants the lowest-index active request and reports its cause code.
// Assumes: req[i] maps to cause code i+1 (see ktu_pkg).
module ktu_prio #(
    parameter int unsigned N = ktu_pkg::NUM_SRC
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic [3:0]   code,
    output logic         any
);

    // Scan from highest index down so the lowest active index is kept last.
    always_comb begin
        grant = '0;
        code  = 4'd0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                code     = 4'(i + 1);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/ktu_timer.sv
// Module: preemption countdown.
// Does: loads on request, counts down by one while running and not frozen,
//       parks at zero, and flags expiry when running at a count of one.
// Assumes: load_en is only asserted by the kernel (gated by the parent).
module ktu_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         freeze,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         expire
);

    localparam logic [W-1:0] ONE = W'(1);

    // Expiry is seen in the cycle before the count reaches zero.
    assign expire = run && (count == ONE);

    // Count register: load has priority, then a guarded decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_en) begin
            count <= load_val;
        end else if (run && !freeze && (count != '0)) begin
            count <= count - ONE;
        end
    end

    AST_TIMER_HOLD_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_en) |=> $stable(count)); // R3
    AST_TIMER_ZERO_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !load_en) |=> (count == '0)); // R4
    AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !load_en) |=> $stable(count)); // R11

endmodule

// File: rtl/ktu_regs.sv
// Module: special register bank.
// Does: captures PC, r7, cause and (for address faults) the fault address on
//       trap entry, and serves a combinational read mux over them.
// Assumes: take is a single-cycle pulse per trap.
module ktu_regs #(
    parameter int unsigned   W        = 16,
    parameter logic [W-1:0]  ISR_ADDR = 16'h0040
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [3:0]   code,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] r7,
    input  logic [W-1:0] fault_addr,
    input  logic [W-1:0] timer_val,
    input  logic [2:0]   rd_sel,
    output logic [W-1:0] rd_data
);
    import ktu_pkg::*;

    logic [W-1:0]       eret_q;
    logic [W-1:0]       ctx_q;
    logic [W-1:0]       eaddr_q;
    logic [CAUSE_W-1:0] cause_q;
    logic               segv_take;

    assign segv_take = take && (code == CAUSE_SEGV);

    // Context capture on trap entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eret_q  <= '0;
            ctx_q   <= '0;
            cause_q <= '0;
        end else if (take) begin
            eret_q  <= pc;
            ctx_q   <= r7;
            cause_q <= code;
        end
    end

    // Fault address is written only by an address-fault trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eaddr_q <= '0;
        end else if (segv_take) begin
            eaddr_q <= fault_addr;
        end
    end

    // Read mux; unused select codes return zero.
    always_comb begin
        case (rsel_e'(rd_sel))
            RSEL_TIMER:   rd_data = timer_val;
            RSEL_CAUSE:   rd_data = W'(cause_q);
            RSEL_ERET:    rd_data = eret_q;
            RSEL_EADDR:   rd_data = eaddr_q;
            RSEL_CONTEXT: rd_data = ctx_q;
            RSEL_ISR:     rd_data = ISR_ADDR;
            default:      rd_data = '0;
        endcase
    end

    AST_EADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !segv_take |=> $stable(eaddr_q)); // R6
    AST_CTX_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (ctx_q == $past(r7) && eret_q == $past(pc))); // R5
    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(cause_q)); // R9

endmodule

// File: rtl/kernel_trap_unit.sv
// Module: kernel trap and preemption controller (top).
// Does: tracks user/kernel mode, masks trap sources in kernel mode, selects
//       one trap by priority, strobes a redirect to the fixed entry address,
//       and runs a user-only preemption countdown.
// Assumes: decode holds cur_pc/cur_r7 valid for the cycle a request is shown;
//          the kernel issues commands only while it runs.
module kernel_trap_unit #(
    parameter int unsigned  W        = 16,
    parameter logic [W-1:0] ISR_ADDR = 16'h0040
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_pc,
    input  logic [W-1:0] cur_r7,
    input  logic         mmu_fault,
    input  logic [W-1:0] mmu_fault_addr,
    input  logic         priv_issue,
    input  logic         sys_req,
    input  logic         io_irq,
    input  logic [1:0]   cmd_op,
    input  logic [W-1:0] cmd_wdata,
    input  logic [2:0]   rd_sel,
    output logic         user_mode,
    output logic         redirect_valid,
    output logic [W-1:0] redirect_pc,
    output logic [W-1:0] rd_data
);
    import ktu_pkg::*;

    logic               mode_q;
    logic [NUM_SRC-1:0] raw_req;
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] grant;
    logic [3:0]         code;
    logic               any_req;
    logic               take;
    logic               freeze;
    logic               load_en;
    logic               enter_en;
    logic               expire;
    logic [W-1:0]       timer_cnt;

    // Source order equals cause order: index 0 = timeout ... index 4 = IO.
    assign raw_req  = {io_irq, sys_req, priv_issue, mmu_fault, expire};
    assign req      = raw_req & {NUM_SRC{mode_q}};
    assign take     = mode_q && any_req;
    assign freeze   = take && (code != CAUSE_TIMEOUT);
    assign load_en  = !mode_q && (kop_e'(cmd_op) == KOP_LOAD_TIMER);
    assign enter_en = !mode_q && (kop_e'(cmd_op) == KOP_ENTER_USER);

    assign user_mode      = mode_q;
    assign redirect_valid = take;
    assign redirect_pc    = ISR_ADDR;

    ktu_prio #(.N(NUM_SRC)) u_prio (
        .req   (req),
        .grant (grant),
        .code  (code),
        .any   (any_req)
    );

    ktu_timer #(.W(W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (mode_q),
        .freeze   (freeze),
        .load_en  (load_en),
        .load_val (cmd_wdata),
        .count    (timer_cnt),
        .expire   (expire)
    );

    ktu_regs #(.W(W), .ISR_ADDR(ISR_ADDR)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .code       (code),
        .pc         (cur_pc),
        .r7         (cur_r7),
        .fault_addr (mmu_fault_addr),
        .timer_val  (timer_cnt),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data)
    );

    // Privilege mode: a trap forces kernel; the kernel may drop to user.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (take) begin
            mode_q <= 1'b0;
        end else if (enter_en) begin
            mode_q <= 1'b1;
        end
    end

    AST_STROBE_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> user_mode); // R9
    AST_TRAP_TO_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !user_mode); // R5
    AST_TIMEOUT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && timer_cnt == W'(1)) |-> redirect_valid); // R4
    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R8
    AST_USER_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && !redirect_valid) |=> user_mode); // R10

endmodule

// File: tb/kernel_trap_unit_bench.sv
// Bench: directed scenarios for kernel_trap_unit, one task per scenario.
module kernel_trap_unit_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [15:0] ISR = 16'h0040;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cur_pc, cur_r7, mmu_fault_addr, cmd_wdata;
    logic        mmu_fault, priv_issue, sys_req, io_irq;
    logic [1:0]  cmd_op;
    logic [2:0]  rd_sel;
    logic        user_mode, redirect_valid;
    logic [15:0] redirect_pc, rd_data;

    int n_chk = 0;
    int n_bad = 0;

    kernel_trap_unit #(.W(16), .ISR_ADDR(ISR)) u_kernel_trap_unit (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cur_r7(cur_r7),
        .mmu_fault(mmu_fault), .mmu_fault_addr(mmu_fault_addr),
        .priv_issue(priv_issue), .sys_req(sys_req), .io_irq(io_irq),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .rd_sel(rd_sel),
        .user_mode(user_mode), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [2:0] s, output logic [15:0] v);
        rd_sel = s;
        #0.2;
        v = rd_data;
    endtask

    task automatic idle();
        mmu_fault = 1'b0; priv_issue = 1'b0; sys_req = 1'b0; io_irq = 1'b0;
        cmd_op = 2'd0; cmd_wdata = '0; mmu_fault_addr = '0;
        cur_pc = '0; cur_r7 = '0; rd_sel = 3'd0;
    endtask

    task automatic load_timer(input logic [15:0] v);
        cmd_op = 2'd1; cmd_wdata = v;
        step();
        cmd_op = 2'd0;
    endtask

    task automatic enter_user();
        cmd_op = 2'd2;
        step();
        cmd_op = 2'd0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1", "user_mode", user_mode, 0);
        chk("R1", "redirect_valid", redirect_valid, 0);
        rd(3'd0, v); chk("R1", "countdown", v, 0);
        rd(3'd1, v); chk("R1", "cause", v, 0);
        rd(3'd2, v); chk("R1", "saved pc", v, 0);
        rd(3'd3, v); chk("R1", "fault addr", v, 0);
        rd(3'd4, v); chk("R1", "saved r7", v, 0);
        rd(3'd5, v); chk("R12", "entry addr", v, ISR);
        rd(3'd7, v); chk("R12", "unused select", v, 0);
    endtask

    task automatic t_load_enter();
        logic [15:0] v;
        load_timer(16'd100);
        rd(3'd0, v); chk("R2", "countdown loaded", v, 100);
        repeat (5) step();
        rd(3'd0, v); chk("R3", "countdown holds in kernel", v, 100);
        enter_user();
        chk("R2", "user_mode after enter", user_mode, 1);
        rd(3'd0, v); chk("R3", "countdown on entry", v, 100);
        repeat (3) step();
        rd(3'd0, v); chk("R3", "countdown after 3 user cycles", v, 97);
    endtask

    task automatic t_cmd_in_user();
        logic [15:0] v;
        cmd_op = 2'd1; cmd_wdata = 16'd5;
        step();
        cmd_op = 2'd0;
        rd(3'd0, v); chk("R10", "user load ignored", v, 96);
        chk("R10", "still user", user_mode, 1);
    endtask

    task automatic t_segv();
        logic [15:0] v, t0;
        rd(3'd0, t0);
        cur_pc = 16'h1234; cur_r7 = 16'hBEEF;
        mmu_fault = 1'b1; mmu_fault_addr = 16'h4321;
        #0.2;
        chk("R5", "strobe on fault", redirect_valid, 1);
        chk("R5", "redirect address", redirect_pc, ISR);
        step();
        idle();
        #0.2;
        chk("R5", "kernel after trap", user_mode, 0);
        chk("R5", "strobe one cycle", redirect_valid, 0);
        rd(3'd2, v); chk("R5", "saved pc", v, 16'h1234);
        rd(3'd4, v); chk("R5", "saved r7", v, 16'hBEEF);
        rd(3'd3, v); chk("R6", "fault addr", v, 16'h4321);
        rd(3'd1, v); chk("R8", "cause segv", v, 2);
        rd(3'd0, v); chk("R11", "countdown frozen", v, t0);
    endtask

    task automatic t_masked();
        logic [15:0] v;
        cur_pc = 16'h5555; cur_r7 = 16'h6666;
        mmu_fault = 1'b1; mmu_fault_addr = 16'h7777;
        priv_issue = 1'b1; sys_req = 1'b1; io_irq = 1'b1;
        #0.2;
        chk("R9", "no strobe in kernel", redirect_valid, 0);
        step();
        idle();
        chk("R9", "mode kernel", user_mode, 0);
        rd(3'd2, v); chk("R9", "saved pc kept", v, 16'h1234);
        rd(3'd1, v); chk("R9", "cause kept", v, 2);
        rd(3'd3, v); chk("R6", "fault addr kept", v, 16'h4321);
    endtask

    task automatic t_priv();
        logic [15:0] v;
        load_timer(16'd0);
        enter_user();
        cur_pc = 16'h2000; priv_issue = 1'b1;
        #0.2;
        chk("R7", "strobe on protected op", redirect_valid, 1);
        step();
        idle();
        rd(3'd1, v); chk("R7", "cause priv", v, 3);
        rd(3'd2, v); chk("R5", "saved pc", v, 16'h2000);
        rd(3'd3, v); chk("R6", "fault addr kept", v, 16'h4321);
        priv_issue = 1'b1;
        #0.2;
        chk("R7", "protected op in kernel", redirect_valid, 0);
        step();
        idle();
        rd(3'd1, v); chk("R7", "cause unchanged", v, 3);
    endtask

    task automatic prio_case(input logic [3:0] r, input logic [15:0] exp,
                             input string what);
        logic [15:0] v;
        enter_user();
        mmu_fault = r[0]; mmu_fault_addr = 16'h0AAA;
        priv_issue = r[1]; sys_req = r[2]; io_irq = r[3];
        step();
        idle();
        rd(3'd1, v); chk("R8", what, v, exp);
        rd(3'd3, v); chk("R6", "fault addr", v, 16'h0AAA);
    endtask

    task automatic t_priority();
        prio_case(4'b1111, 16'd2, "segv wins");
        prio_case(4'b1110, 16'd3, "priv wins");
        prio_case(4'b1100, 16'd4, "syscall wins");
        prio_case(4'b1000, 16'd5, "io alone");
    endtask

    task automatic t_timeout();
        logic [15:0] v;
        int seen;
        load_timer(16'd3);
        enter_user();
        step();
        chk("R4", "no early timeout", redirect_valid, 0);
        step();
        #0.2;
        chk("R4", "timeout strobe at one", redirect_valid, 1);
        step();
        chk("R4", "kernel after timeout", user_mode, 0);
        rd(3'd1, v); chk("R4", "cause timeout", v, 1);
        rd(3'd0, v); chk("R4", "countdown zero", v, 0);
        enter_user();
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            #0.2;
            if (redirect_valid) seen++;
            step();
        end
        chk("R4", "zero countdown silent", seen, 0);
        rd(3'd0, v); chk("R3", "zero holds", v, 0);
        io_irq = 1'b1;
        step();
        idle();
        load_timer(16'd2);
        enter_user();
        step();
        io_irq = 1'b1; mmu_fault = 1'b1; mmu_fault_addr = 16'h0BBB;
        step();
        idle();
        rd(3'd1, v); chk("R8", "timeout beats others", v, 1);
        rd(3'd3, v); chk("R6", "losing fault not stored", v, 16'h0AAA);
        rd(3'd0, v); chk("R4", "countdown zero", v, 0);
    endtask

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_load_enter();
        t_cmd_in_user();
        t_segv();
        t_masked();
        t_priv();
        t_priority();
        t_timeout();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all R): actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule